// File: doc/BRIEF.md
# Framed Byte-Stream Deframer

This block sits behind a byte-wide serial receiver, for example the byte-valid output of an SPI slave shifter. It watches the incoming byte stream for a two-byte start marker and then walks through the frame: a sequence byte, a length byte, exactly that many payload bytes and a two-byte CRC trailer. A CRC-16 with the CCITT polynomial is computed as the bytes arrive.

Each payload byte leaves the block as a single valid beat with a last flag on the final beat. No payload is buffered. When the trailer has been received, the block pulses either a good-frame or a bad-frame verdict. For each good frame it also compares the sequence number with that of the previous good frame and flags any gap.

A run of ten fill bytes (0xFF) acts as a resynchronisation command. It throws away whatever frame is in progress and returns the block to marker hunting. The block reports this with a pulse.

Top module: `frame_deframer`

## Requirements
- R1: After reset, and after every verdict, the block hunts for the marker byte 0xAA immediately followed by 0x55. No other byte produces a beat or a verdict while it hunts.
- R2: If 0xAA is followed by another 0xAA, the second 0xAA is treated as a fresh first marker byte. The sequence 0xAA 0xAA 0x55 therefore starts a frame.
- R3: After the marker, the frame carries one sequence byte, one length byte N (0 to 255), N payload bytes and then two trailer bytes. A frame with N = 255 is handled fully.
- R4: Each payload byte accepted on a cycle with `in_valid` high appears on `out_data` with `out_valid` high for exactly one cycle, on the cycle after it was accepted.
- R5: `out_last` is high together with the beat of the final payload byte and at no other time. A frame with N = 0 produces no beats.
- R6: The CRC uses polynomial 0x1021 with initial value 0xFFFF and covers the marker, sequence, length and payload bytes, processed most significant bit first. The trailer carries this CRC high byte first. When the trailer matches, `frame_ok` pulses for one cycle, on the cycle after the last trailer byte.
- R7: When the trailer does not match, `frame_bad` pulses in place of `frame_ok`. `frame_ok` and `frame_bad` are never high together.
- R8: `seq_gap` pulses together with `frame_ok` when the good frame's sequence number is not the previous good frame's sequence number plus one, modulo 256. The first good frame after reset or after a resync never raises `seq_gap`.
- R9: Ten consecutive accepted 0xFF bytes pulse `resync` on the cycle after the tenth byte, from any state, and return the block to hunting. The tenth byte produces no beat or verdict. The run counter then restarts from zero. Cycles with `in_valid` low do not break a run, and any other accepted byte clears it. A run of nine has no effect.
- R10: A cycle with `in_valid` low changes no state. On the next cycle there is no beat, no verdict and no resync pulse.
- R11: While `rst_n` is low, all outputs are zero and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | High when in_byte carries a new stream byte |
| in_byte | input | 8 | Incoming stream byte |
| out_valid | output | 1 | Payload beat valid (one cycle per byte) |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte of the frame |
| frame_ok | output | 1 | Pulse: trailer matched the computed CRC |
| frame_bad | output | 1 | Pulse: trailer mismatched, frame discarded |
| seq_gap | output | 1 | Pulse with frame_ok: sequence number did not follow the previous good frame |
| resync | output | 1 | Pulse: fill-byte run detected, receiver back to hunting |

## Verification
The assertions assume that `in_valid` is never unknown once reset is released, and that `in_byte` is stable across the clock edge on any cycle where `in_valid` is high. The bench changes both inputs only on falling clock edges and holds them at known values from time zero, so it stays within these assumptions. The assertions place no limit on byte content or on how bytes and idle cycles interleave. The stimulus relies on this by mixing well-formed frames with corrupted trailers, false markers, fill runs inside payloads, idle cycles within frames and random byte streams.

// File: rtl/deframer_pkg.sv
package deframer_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_MARK2,
    ST_SEQ,
    ST_LEN,
    ST_PAY,
    ST_CHI,
    ST_CLO
  } dfr_state_t;

  typedef enum logic [1:0] {
    CRC_HOLD,
    CRC_SEED,
    CRC_FOLD
  } crc_op_t;

  // Folds one byte into a 16-bit CRC, most significant bit first.
  function automatic logic [15:0] crc_fold(input logic [15:0] cur,
                                           input logic [7:0]  data,
                                           input logic [15:0] poly);
    logic [15:0] r;
    r = cur ^ {data, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/dfr_crc16.sv
module dfr_crc16
  import deframer_pkg::*;
#(
  parameter logic [15:0] POLY = 16'h1021,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  crc_op_t       op,
  input  logic [7:0]    data,
  output logic [15:0]   crc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= INIT;
    end else begin
      case (op)
        CRC_SEED: crc_q <= crc_fold(INIT, data, POLY);
        CRC_FOLD: crc_q <= crc_fold(crc_q, data, POLY);
        default:  crc_q <= crc_q;
      endcase
    end
  end

  // R6: the register only moves when the frame logic asks it to
  a_r6_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op == CRC_HOLD) |=> $stable(crc_q));

endmodule

// File: rtl/dfr_fill_detect.sv
module dfr_fill_detect #(
  parameter logic [7:0] FILL_BYTE = 8'hFF,
  parameter int         FILL_RUN  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       fire
);

  localparam int CW = $clog2(FILL_RUN + 1);

  logic [CW-1:0] run_q;
  logic          is_fill;

  assign is_fill = in_valid && (in_byte == FILL_BYTE);
  assign fire    = is_fill && (run_q == CW'(FILL_RUN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (in_valid) begin
      if (!is_fill || fire) run_q <= '0;
      else                  run_q <= run_q + CW'(1);
    end
  end

  // R9: the run counter never reaches the trigger length without firing
  a_r9_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(FILL_RUN));

  // R9: after a fire the next run starts from zero
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (run_q == '0));

endmodule

// File: rtl/dfr_seq_track.sv
module dfr_seq_track #(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             judge,
  input  logic [SEQ_W-1:0] seq_in,
  output logic             gap
);

  logic             have_q;
  logic [SEQ_W-1:0] last_q;

  assign gap = judge && have_q && (seq_in != last_q + SEQ_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (clear) begin
      have_q <= 1'b0;
    end else if (judge) begin
      have_q <= 1'b1;
      last_q <= seq_in;
    end
  end

  // R8: a resync and a good verdict never share a cycle
  a_r8_clear_judge_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear && judge));

  // R8: the first judged frame after a clear cannot be a gap
  a_r8_first_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !gap);

endmodule

// File: rtl/frame_deframer.sv
module frame_deframer
  import deframer_pkg::*;
#(
  parameter logic [7:0]  MARK_HI   = 8'hAA,
  parameter logic [7:0]  MARK_LO   = 8'h55,
  parameter logic [7:0]  FILL_BYTE = 8'hFF,
  parameter int          FILL_RUN  = 10,
  parameter logic [15:0] CRC_POLY  = 16'h1021,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       frame_ok,
  output logic       frame_bad,
  output logic       seq_gap,
  output logic       resync
);

  localparam int BYTE_W = 8;

  dfr_state_t        state_q, state_d;
  logic [BYTE_W-1:0] seq_q, left_q, crc_hi_q;
  logic [15:0]       crc_q;
  crc_op_t           crc_op;

  // named internal events
  logic fill_fire, beat_now, last_now, good_now, bad_now, gap_now;
  logic seq_load, len_load, hi_load, left_dec;

  dfr_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (crc_op),
    .data  (in_byte),
    .crc_q (crc_q)
  );

  dfr_fill_detect #(.FILL_BYTE(FILL_BYTE), .FILL_RUN(FILL_RUN)) u_fill (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .fire     (fill_fire)
  );

  dfr_seq_track #(.SEQ_W(BYTE_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (fill_fire),
    .judge  (good_now),
    .seq_in (seq_q),
    .gap    (gap_now)
  );

  always_comb begin
    state_d  = state_q;
    crc_op   = CRC_HOLD;
    beat_now = 1'b0;
    last_now = 1'b0;
    good_now = 1'b0;
    bad_now  = 1'b0;
    seq_load = 1'b0;
    len_load = 1'b0;
    hi_load  = 1'b0;
    left_dec = 1'b0;
    if (in_valid) begin
      if (fill_fire) begin
        state_d = ST_HUNT;
      end else begin
        case (state_q)
          ST_HUNT: begin
            if (in_byte == MARK_HI) begin
              state_d = ST_MARK2;
              crc_op  = CRC_SEED;
            end
          end
          ST_MARK2: begin
            if (in_byte == MARK_LO) begin
              state_d = ST_SEQ;
              crc_op  = CRC_FOLD;
            end else if (in_byte == MARK_HI) begin
              crc_op  = CRC_SEED;
            end else begin
              state_d = ST_HUNT;
            end
          end
          ST_SEQ: begin
            seq_load = 1'b1;
            crc_op   = CRC_FOLD;
            state_d  = ST_LEN;
          end
          ST_LEN: begin
            len_load = 1'b1;
            crc_op   = CRC_FOLD;
            state_d  = (in_byte == '0) ? ST_CHI : ST_PAY;
          end
          ST_PAY: begin
            beat_now = 1'b1;
            left_dec = 1'b1;
            crc_op   = CRC_FOLD;
            last_now = (left_q == BYTE_W'(1));
            if (last_now) state_d = ST_CHI;
          end
          ST_CHI: begin
            hi_load = 1'b1;
            state_d = ST_CLO;
          end
          ST_CLO: begin
            state_d = ST_HUNT;
            if ({crc_hi_q, in_byte} == crc_q) good_now = 1'b1;
            else                              bad_now  = 1'b1;
          end
          default: state_d = ST_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HUNT;
      seq_q    <= '0;
      left_q   <= '0;
      crc_hi_q <= '0;
    end else begin
      state_q <= state_d;
      if (seq_load) seq_q    <= in_byte;
      if (hi_load)  crc_hi_q <= in_byte;
      if (len_load)      left_q <= in_byte;
      else if (left_dec) left_q <= left_q - BYTE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      frame_ok  <= 1'b0;
      frame_bad <= 1'b0;
      seq_gap   <= 1'b0;
      resync    <= 1'b0;
    end else begin
      out_valid <= beat_now;
      out_last  <= last_now;
      frame_ok  <= good_now;
      frame_bad <= bad_now;
      seq_gap   <= gap_now;
      resync    <= fill_fire;
      if (beat_now) out_data <= in_byte;
    end
  end

  // R7: never both verdicts at once
  a_r7_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && frame_bad));

  // R8: a gap is only reported on a good frame
  a_r8_gap_with_ok: assert property (@(posedge clk) disable iff (!rst_n)
    seq_gap |-> frame_ok);

  // R5: last flag rides on a beat and is followed by the trailer
  a_r5_last_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && state_q == ST_CHI));

  // R4: beats come only from bytes taken in the payload state
  a_r4_beat_from_payload: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(state_q) == ST_PAY));

  // R10: an idle input cycle produces no event
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(out_valid || frame_ok || frame_bad || resync));

  // R9: a resync leaves the receiver hunting
  a_r9_resync_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    resync |-> (state_q == ST_HUNT));

  // R1: every verdict returns the receiver to hunting
  a_r1_verdict_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok || frame_bad) |-> (state_q == ST_HUNT));

endmodule

// File: tb/test_frame_deframer.sv
module test_frame_deframer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid, out_last, frame_ok, frame_bad, seq_gap, resync;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  frame_deframer i_frame_deframer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .frame_ok(frame_ok), .frame_bad(frame_bad), .seq_gap(seq_gap),
    .resync(resync)
  );

  // reference model state
  int  m_st = 0;
  int  m_crc = 0, m_seq = 0, m_left = 0, m_hi = 0, m_fill = 0, m_last = 0;
  bit  m_have = 0;
  bit  x_valid, x_last, x_ok, x_bad, x_gap, x_rs;
  int  x_data = 0;
  int  n_ok = 0, n_bad = 0, n_gap = 0, n_rs = 0, n_beats = 0;

  // byte-wise CCITT update in closed form
  function automatic int crc_step(int c, int b);
    int x;
    x = ((c >> 8) ^ b) & 255;
    x = x ^ (x >> 4);
    return ((c << 8) ^ (x << 12) ^ (x << 5) ^ x) & 16'hFFFF;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check("R4 out_valid", out_valid, x_valid);
    if (x_valid) check("R4 out_data", out_data, x_data);
    check("R5 out_last", out_last, x_last);
    check("R6 frame_ok", frame_ok, x_ok);
    check("R7 frame_bad", frame_bad, x_bad);
    check("R8 seq_gap", seq_gap, x_gap);
    check("R9 resync", resync, x_rs);
    n_ok += int'(frame_ok);
    n_bad += int'(frame_bad);
    n_gap += int'(seq_gap);
    n_rs += int'(resync);
    n_beats += int'(out_valid);
  endtask

  function automatic void model(bit v, int b);
    x_valid = 0; x_last = 0; x_ok = 0; x_bad = 0; x_gap = 0; x_rs = 0;
    if (!v) return;
    if (b == 255) m_fill++;
    else m_fill = 0;
    if (m_fill == 10) begin
      m_fill = 0; x_rs = 1; m_st = 0; m_have = 0;
      return;
    end
    case (m_st)
      0: if (b == 170) begin m_st = 1; m_crc = crc_step(16'hFFFF, b); end
      1: if (b == 85) begin m_st = 2; m_crc = crc_step(m_crc, b); end
         else if (b == 170) m_crc = crc_step(16'hFFFF, b);
         else m_st = 0;
      2: begin m_seq = b; m_crc = crc_step(m_crc, b); m_st = 3; end
      3: begin m_left = b; m_crc = crc_step(m_crc, b); m_st = (b == 0) ? 5 : 4; end
      4: begin
           x_valid = 1; x_data = b; m_crc = crc_step(m_crc, b);
           m_left--;
           if (m_left == 0) begin x_last = 1; m_st = 5; end
         end
      5: begin m_hi = b; m_st = 6; end
      default: begin
           m_st = 0;
           if (((m_hi << 8) | b) == m_crc) begin
             x_ok = 1;
             if (m_have && m_seq != ((m_last + 1) & 255)) x_gap = 1;
             m_have = 1; m_last = m_seq;
           end else x_bad = 1;
         end
    endcase
  endfunction

  task automatic step(bit v, int b);
    @(negedge clk);
    compare();
    model(v, b);
    in_valid = v;
    in_byte = 8'(b);
  endtask

  task automatic send_frame(int seq, int pl[$], bit corrupt, int idle_every);
    int f[$];
    int c;
    f.push_back(170); f.push_back(85); f.push_back(seq); f.push_back(pl.size());
    foreach (pl[i]) f.push_back(pl[i]);
    c = 16'hFFFF;
    foreach (f[i]) c = crc_step(c, f[i]);
    f.push_back(c >> 8);
    f.push_back((c & 255) ^ int'(corrupt));
    foreach (f[i]) begin
      step(1, f[i]);
      if (idle_every > 0 && (i % idle_every) == idle_every - 1) step(0, 0);
    end
  endtask

  task automatic flush();
    step(0, 0);
    step(0, 0);
  endtask

  int b_ok, b_bad, b_gap, b_rs, b_beats;
  task automatic mark();
    b_ok = n_ok; b_bad = n_bad; b_gap = n_gap; b_rs = n_rs; b_beats = n_beats;
  endtask

  task automatic expect_counts(string tag, int ok, int bad, int gap, int rs, int beats);
    check({tag, " ok count"}, n_ok - b_ok, ok);
    check({tag, " bad count"}, n_bad - b_bad, bad);
    check({tag, " gap count"}, n_gap - b_gap, gap);
    check({tag, " resync count"}, n_rs - b_rs, rs);
    check({tag, " beat count"}, n_beats - b_beats, beats);
  endtask

  initial begin
    int pl[$];
    repeat (3) @(negedge clk);
    // R11: outputs during reset
    check("R11 reset outputs", int'({out_valid, out_last, frame_ok, frame_bad, seq_gap, resync}), 0);
    rst_n = 1'b1;

    // R3 R4 R6: basic good frame
    mark(); pl = '{8'h11, 8'h22, 8'h33};
    send_frame(5, pl, 0, 0); flush();
    expect_counts("R3 R6 basic", 1, 0, 0, 0, 3);

    // R8: 5 -> 7 gap
    mark(); pl = '{8'h44};
    send_frame(7, pl, 0, 0); flush();
    expect_counts("R8 gap", 1, 0, 1, 0, 1);

    // R5: zero-length frame
    mark(); pl = '{};
    send_frame(8, pl, 0, 0); flush();
    expect_counts("R5 zero length", 1, 0, 0, 0, 0);

    // R7: corrupted trailer
    mark(); pl = '{8'h01, 8'h02};
    send_frame(9, pl, 1, 0); flush();
    expect_counts("R7 bad crc", 0, 1, 0, 0, 2);

    // R1: false marker pieces before a frame
    mark();
    step(1, 8'h12); step(1, 8'hAA); step(1, 8'h12); step(1, 8'h55); step(1, 8'h00);
    pl = '{8'h5A};
    send_frame(9, pl, 0, 0); flush();
    expect_counts("R1 hunt", 1, 0, 0, 0, 1);

    // R2: doubled first marker byte
    mark(); step(1, 8'hAA);
    pl = '{8'h77, 8'h88};
    send_frame(10, pl, 0, 0); flush();
    expect_counts("R2 remarker", 1, 0, 0, 0, 2);

    // R8: wrap 255 -> 0 (10 -> 255 is a gap, 255 -> 0 is not)
    mark(); pl = '{8'h01};
    send_frame(255, pl, 0, 0); send_frame(0, pl, 0, 0); flush();
    expect_counts("R8 wrap", 2, 0, 1, 0, 2);

    // R9: resync in the middle of a payload
    mark();
    step(1, 8'hAA); step(1, 8'h55); step(1, 1); step(1, 20); step(1, 1);
    for (int i = 0; i < 10; i++) step(1, 8'hFF);
    flush();
    expect_counts("R9 resync", 0, 0, 0, 1, 10);
    mark(); pl = '{8'h42};
    send_frame(42, pl, 0, 0); flush();
    expect_counts("R9 first after resync", 1, 0, 0, 0, 1);

    // R9: nine fill bytes are ordinary payload
    mark(); pl = '{};
    for (int i = 0; i < 9; i++) pl.push_back(8'hFF);
    pl.push_back(8'h00); pl.push_back(8'h01); pl.push_back(8'h02);
    send_frame(43, pl, 0, 0); flush();
    expect_counts("R9 nine fills", 1, 0, 0, 0, 12);

    // R10: idle cycles inside a frame
    mark(); pl = '{8'h10, 8'h20, 8'h30, 8'h40};
    send_frame(44, pl, 0, 2); flush();
    expect_counts("R10 idle", 1, 0, 0, 0, 4);

    // R3: maximum length
    mark(); pl = '{};
    for (int i = 0; i < 255; i++) pl.push_back((i * 7) & 255);
    send_frame(45, pl, 0, 0); flush();
    expect_counts("R3 long", 1, 0, 0, 0, 255);

    // random streams mixed with frames, compared cycle by cycle
    for (int k = 0; k < 40; k++) begin
      for (int j = 0; j < 30; j++) step(($urandom % 4) != 0, $urandom % 256);
      pl = '{};
      for (int j = 0; j < ($urandom % 6); j++) pl.push_back($urandom % 256);
      send_frame($urandom % 256, pl, ($urandom % 3) == 0, $urandom % 4);
    end
    flush();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule